// File: doc/BRIEF.md
# Serial-memory image loader with checksum guard

This block sits between a word-wide serial memory master and the logic that consumes a 64-word configuration image. On command it reads every word of the image in turn and stores it in a local register cache. It keeps a 16-bit running sum as the words arrive. At the end it judges the image on two points. The wrap-around sum must hit a fixed target. The top two bits of cache word 0 must carry the valid signature. A second command rebuilds the fix-up word: it sums words 0 to 62 and writes the difference from the target into word 63.

Consumers read words through a lookup port. If the cached signature is intact, the answer comes straight from the cache. If it is not, the block first runs a full reload and then answers. An index beyond the image, or an image that fails its checks, yields a zero word with the valid flag low. The block invalidates its own cache in three cases: a failed checksum, a write to the memory, or a timeout reported by the master.

Top module: `eeprom_image_loader`

## Requirements
- R1: After reset, `busy`, `mem_req`, `cmd_done`, `lk_ack` and `err_flag` are all low, and the cache signature is invalid.
- R2: A load issues exactly 64 reads at addresses 0, 1, ..., 63 in ascending order. Only one request is open at a time. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_done` or `mem_timeout` arrives.
- R3: A load ends with a one-cycle `cmd_done`. `cmd_ok` is high only if the 16-bit wrap-around sum of all 64 words equals 0xBABA and (word0 & 0xC000) == 0x4000.
- R4: When the sum check fails, cache word 0 is set to 0x0000 and the load reports failure. A later lookup therefore triggers a reload and does not take a cache hit.
- R5: When the sum is correct but (word0 & 0xC000) != 0x4000, the load reports failure.
- R6: A lookup with index below 64 and a valid cached signature answers with one `lk_ack`, `lk_valid` high and the cached word. It issues no memory traffic.
- R7: A lookup with index below 64 and an invalid cached signature first performs a full 64-word reload. It then answers with the new word if the reload passes, and with 0x0000 and `lk_valid` low otherwise.
- R8: A lookup with index 64 or more answers with data 0x0000 and `lk_valid` low. It issues no memory traffic.
- R9: An update reads words 0 to 62 (63 reads) and then performs one write to address 63 with data (0xBABA - sum) mod 2^16. It ends with `cmd_done` and `cmd_ok` high.
- R10: Any write through the block clears cache word 0, so the next lookup reloads.
- R11: A `mem_timeout` aborts the current operation, sets `err_flag` and leaves the cache signature invalid. An aborted command ends with `cmd_done` and `cmd_ok` low. An aborted lookup reload answers 0x0000 with `lk_valid` low. `err_flag` clears when the next load or update is accepted.
- R12: `cmd_load`, `cmd_update` and `lk_req` are one-cycle pulses, sampled only while `busy` is low. If more than one arrives in the same cycle, load wins over update, and update wins over lookup; the losers are dropped. An operation produces either `cmd_done` or `lk_ack`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_load | input | 1 | Pulse: load and validate the whole image |
| cmd_update | input | 1 | Pulse: recompute and write the fix-up word |
| busy | output | 1 | An operation is in progress; new pulses are ignored |
| cmd_done | output | 1 | One-cycle end of a load or update |
| cmd_ok | output | 1 | Outcome of the last command, valid with `cmd_done` |
| err_flag | output | 1 | A memory timeout occurred since the last accepted command |
| lk_req | input | 1 | Pulse: look up one word |
| lk_index | input | 7 | Word index for the lookup |
| lk_ack | output | 1 | One-cycle lookup answer strobe |
| lk_data | output | 16 | Looked-up word, zero when not valid |
| lk_valid | output | 1 | Looked-up word comes from a validated image |
| mem_req | output | 1 | Memory request open |
| mem_we | output | 1 | Open request is a write |
| mem_addr | output | 6 | Word address of the open request |
| mem_wdata | output | 16 | Write data of the open request |
| mem_rdata | input | 16 | Read data, valid with `mem_done` |
| mem_done | input | 1 | One-cycle completion of the open request |
| mem_timeout | input | 1 | One-cycle abort of the open request |

## Verification
The hardest case to reach from the ports is a lookup that starts a reload which is then cut short. The same holds for an update that dies midway. In both, the cache must stay invalid and the error flag must rise without `cmd_ok`. The bench's memory model takes a target read count. When that count is reached it answers with a timeout instead of data, so the abort lands deep inside a read burst. Follow-up lookups then show through the read counter whether the cache was left invalid. The bench also covers a checksum failure on an image whose signature is good. Only the forced clearing of word 0 separates that case from a cache hit.

// File: rtl/eil_pkg.sv
// Shared types for the image loader: sequencer states and operation kinds.
package eil_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_JUDGE,
        ST_WRITE,
        ST_ANSWER
    } eil_state_t;

    typedef enum logic [1:0] {
        OP_LOAD,
        OP_UPD,
        OP_LOOK
    } eil_op_t;
endpackage

// File: rtl/eil_cache.sv
// Register cache of the image words plus the signature decoder.
// Assumes: one write per cycle; a signature clear overrides a write to word 0.
module eil_cache #(
    parameter int          WORDS     = 64,
    parameter int          DW        = 16,
    parameter int          AW        = 6,
    parameter logic [15:0] SIG_MASK  = 16'hC000,
    parameter logic [15:0] SIG_VALID = 16'h4000,
    parameter logic [15:0] SIG_CLEAR = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          sig_clr,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          sig_ok
);
    logic [DW-1:0] mem_q [WORDS];

    // Store arriving words; the signature clear wins over a write to word 0.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (i == 0 && sig_clr) begin
                mem_q[i] <= DW'(SIG_CLEAR);
            end else if (wr_en && wr_addr == AW'(i)) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    // Read port and signature decode of word 0.
    always_comb begin
        rd_data = mem_q[rd_addr];
        sig_ok  = (mem_q[0] & DW'(SIG_MASK)) == DW'(SIG_VALID);
    end

    // R4
    sig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_clr |=> !sig_ok);
endmodule

// File: rtl/eil_seq.sv
// Sequencer: runs loads, checksum updates and lookups over a one-request
// memory port. Assumes the master answers each open request with exactly one
// mem_done or mem_timeout pulse, and that command pulses arrive while idle.
module eil_seq
    import eil_pkg::*;
#(
    parameter int          WORDS      = 64,
    parameter int          DW         = 16,
    parameter int          AW         = 6,
    parameter int          IW         = 7,
    parameter logic [15:0] SUM_TARGET = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_load,
    input  logic          cmd_update,
    input  logic          lk_req,
    input  logic [IW-1:0] lk_index,
    output logic          busy,
    output logic          cmd_done,
    output logic          cmd_ok,
    output logic          err_flag,
    output logic          lk_ack,
    output logic [DW-1:0] lk_data,
    output logic          lk_valid,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_done,
    input  logic          mem_timeout,
    output logic          c_wr_en,
    output logic [AW-1:0] c_wr_addr,
    output logic [DW-1:0] c_wr_data,
    output logic          c_sig_clr,
    output logic [AW-1:0] c_rd_addr,
    input  logic [DW-1:0] c_rd_data,
    input  logic          c_sig_ok
);
    localparam logic [AW-1:0] LAST_W  = AW'(WORDS - 1);
    localparam logic [AW-1:0] LAST_CK = AW'(WORDS - 2);
    localparam logic [IW-1:0] LIMIT   = IW'(WORDS);

    eil_state_t    st;
    eil_op_t       op;
    logic [AW-1:0] addr, idx_q;
    logic [DW-1:0] sum, fix, data_q;
    logic          hit_q, done_q, ok_q, err_q, ack_q, valid_q;
    logic [AW-1:0] last_rd;
    logic          judge_pass;

    // Port drives and cache control derived from the current state.
    always_comb begin
        last_rd    = (op == OP_UPD) ? LAST_CK : LAST_W;
        judge_pass = (sum == DW'(SUM_TARGET)) && c_sig_ok;
        busy       = (st != ST_IDLE);
        mem_req    = (st == ST_READ) || (st == ST_WRITE);
        mem_we     = (st == ST_WRITE);
        mem_addr   = addr;
        mem_wdata  = fix;
        c_wr_en    = (st == ST_READ) && mem_done && !mem_timeout && (op != OP_UPD);
        c_wr_addr  = addr;
        c_wr_data  = mem_rdata;
        c_rd_addr  = idx_q;
        c_sig_clr  = ((st == ST_READ) && mem_timeout)
                   || ((st == ST_WRITE) && (mem_done || mem_timeout))
                   || ((st == ST_JUDGE) && (op != OP_UPD) && (sum != DW'(SUM_TARGET)));
        cmd_done   = done_q;
        cmd_ok     = ok_q;
        err_flag   = err_q;
        lk_ack     = ack_q;
        lk_data    = data_q;
        lk_valid   = valid_q;
    end

    // Operation sequencing, running sum and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            op      <= OP_LOAD;
            addr    <= '0;
            idx_q   <= '0;
            sum     <= '0;
            fix     <= '0;
            data_q  <= '0;
            hit_q   <= 1'b0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
            ack_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ack_q  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    addr <= '0;
                    sum  <= '0;
                    if (cmd_load) begin
                        op    <= OP_LOAD;
                        err_q <= 1'b0;
                        st    <= ST_READ;
                    end else if (cmd_update) begin
                        op    <= OP_UPD;
                        err_q <= 1'b0;
                        st    <= ST_READ;
                    end else if (lk_req) begin
                        idx_q <= lk_index[AW-1:0];
                        if (lk_index >= LIMIT) begin
                            hit_q <= 1'b0;
                            st    <= ST_ANSWER;
                        end else if (c_sig_ok) begin
                            hit_q <= 1'b1;
                            st    <= ST_ANSWER;
                        end else begin
                            op <= OP_LOOK;
                            st <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_timeout) begin
                        err_q <= 1'b1;
                        if (op == OP_LOOK) begin
                            hit_q <= 1'b0;
                            st    <= ST_ANSWER;
                        end else begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b0;
                            st     <= ST_IDLE;
                        end
                    end else if (mem_done) begin
                        sum <= sum + mem_rdata;
                        if (addr == last_rd) st <= ST_JUDGE;
                        else                 addr <= addr + AW'(1);
                    end
                end
                ST_JUDGE: begin
                    if (op == OP_UPD) begin
                        fix  <= DW'(SUM_TARGET) - sum;
                        addr <= LAST_W;
                        st   <= ST_WRITE;
                    end else if (op == OP_LOOK) begin
                        hit_q <= judge_pass;
                        st    <= ST_ANSWER;
                    end else begin
                        done_q <= 1'b1;
                        ok_q   <= judge_pass;
                        st     <= ST_IDLE;
                    end
                end
                ST_WRITE: begin
                    if (mem_timeout || mem_done) begin
                        err_q  <= err_q | mem_timeout;
                        done_q <= 1'b1;
                        ok_q   <= !mem_timeout;
                        st     <= ST_IDLE;
                    end
                end
                ST_ANSWER: begin
                    ack_q   <= 1'b1;
                    valid_q <= hit_q;
                    data_q  <= hit_q ? c_rd_data : '0;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done && !mem_timeout) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == LAST_W));

    // R11
    tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_timeout) |=> err_flag);

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ack && !lk_valid) |-> (lk_data == '0));

    // R3
    load_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_ok && op == OP_LOAD) |-> c_sig_ok);

    // R12
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !lk_ack);
endmodule

// File: rtl/eeprom_image_loader.sv
// Top of the image loader: the sequencer driving the memory port and the
// register cache it fills. Assumes a single clock and a synchronous reset.
module eeprom_image_loader #(
    parameter int          WORDS      = 64,
    parameter int          DW         = 16,
    parameter logic [15:0] SUM_TARGET = 16'hBABA,
    parameter logic [15:0] SIG_MASK   = 16'hC000,
    parameter logic [15:0] SIG_VALID  = 16'h4000,
    parameter logic [15:0] SIG_CLEAR  = 16'h0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_load,
    input  logic                       cmd_update,
    output logic                       busy,
    output logic                       cmd_done,
    output logic                       cmd_ok,
    output logic                       err_flag,
    input  logic                       lk_req,
    input  logic [$clog2(WORDS):0]     lk_index,
    output logic                       lk_ack,
    output logic [DW-1:0]              lk_data,
    output logic                       lk_valid,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [$clog2(WORDS)-1:0]   mem_addr,
    output logic [DW-1:0]              mem_wdata,
    input  logic [DW-1:0]              mem_rdata,
    input  logic                       mem_done,
    input  logic                       mem_timeout
);
    localparam int AW = $clog2(WORDS);
    localparam int IW = AW + 1;

    logic          c_wr_en, c_sig_clr, c_sig_ok;
    logic [AW-1:0] c_wr_addr, c_rd_addr;
    logic [DW-1:0] c_wr_data, c_rd_data;

    eil_seq #(
        .WORDS(WORDS), .DW(DW), .AW(AW), .IW(IW), .SUM_TARGET(SUM_TARGET)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_load(cmd_load), .cmd_update(cmd_update),
        .lk_req(lk_req), .lk_index(lk_index),
        .busy(busy), .cmd_done(cmd_done), .cmd_ok(cmd_ok), .err_flag(err_flag),
        .lk_ack(lk_ack), .lk_data(lk_data), .lk_valid(lk_valid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done), .mem_timeout(mem_timeout),
        .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data),
        .c_sig_clr(c_sig_clr), .c_rd_addr(c_rd_addr),
        .c_rd_data(c_rd_data), .c_sig_ok(c_sig_ok)
    );

    eil_cache #(
        .WORDS(WORDS), .DW(DW), .AW(AW),
        .SIG_MASK(SIG_MASK), .SIG_VALID(SIG_VALID), .SIG_CLEAR(SIG_CLEAR)
    ) cache_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(c_wr_en), .wr_addr(c_wr_addr), .wr_data(c_wr_data),
        .sig_clr(c_sig_clr), .rd_addr(c_rd_addr),
        .rd_data(c_rd_data), .sig_ok(c_sig_ok)
    );
endmodule

// File: tb/eeprom_image_loader_tb_top.sv
module eeprom_image_loader_tb_top;
    localparam int          WORDS  = 64;
    localparam logic [15:0] TARGET = 16'hBABA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        cmd_load = 1'b0, cmd_update = 1'b0, lk_req = 1'b0;
    logic [6:0]  lk_index = '0;
    logic        busy, cmd_done, cmd_ok, err_flag, lk_ack, lk_valid;
    logic [15:0] lk_data;
    logic        mem_req, mem_we;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_done = 1'b0, mem_timeout = 1'b0;

    eeprom_image_loader dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_load(cmd_load), .cmd_update(cmd_update),
        .busy(busy), .cmd_done(cmd_done), .cmd_ok(cmd_ok), .err_flag(err_flag),
        .lk_req(lk_req), .lk_index(lk_index),
        .lk_ack(lk_ack), .lk_data(lk_data), .lk_valid(lk_valid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done), .mem_timeout(mem_timeout)
    );

    // Memory model: fixed latency, optional timeout at a chosen read count.
    logic [15:0] img  [WORDS];
    logic [15:0] bimg [WORDS];
    logic        img_load = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0, order_bad = 0, lat = 0;
    int          to_at = -1;
    logic [5:0]  prev_rd = '0, last_waddr = '0;
    logic [15:0] last_wdata = '0;

    always @(posedge clk) begin
        if (img_load) img <= bimg;
        if (mem_req && !mem_done && !mem_timeout) begin
            if (lat == 2) begin
                lat <= 0;
                if (!mem_we && rd_cnt == to_at) begin
                    mem_timeout <= 1'b1;
                end else begin
                    mem_done <= 1'b1;
                    if (mem_we) begin
                        img[mem_addr] <= mem_wdata;
                        wr_cnt        <= wr_cnt + 1;
                        last_wdata    <= mem_wdata;
                        last_waddr    <= mem_addr;
                    end else begin
                        mem_rdata <= img[mem_addr];
                        rd_cnt    <= rd_cnt + 1;
                        if (mem_addr != 6'd0 && int'(mem_addr) != int'(prev_rd) + 1)
                            order_bad <= order_bad + 1;
                        prev_rd <= mem_addr;
                    end
                end
            end else begin
                lat <= lat + 1;
            end
        end else begin
            mem_done    <= 1'b0;
            mem_timeout <= 1'b0;
        end
    end

    // Scoreboard: the driver queues expected results, the monitor compares.
    typedef struct {
        bit          is_look;
        bit          ok;
        logic [15:0] data;
        bit          err;
        int          rq;
    } exp_t;
    exp_t sb[$];
    int   mon_checks = 0, mon_errs = 0;

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (cmd_done || lk_ack)) begin
            mon_checks++;
            if (sb.size() == 0) begin
                mon_errs++;
                $display("FAIL R12 unexpected result done=%0b ack=%0b expected none",
                         cmd_done, lk_ack);
            end else begin
                e = sb.pop_front();
                if (e.is_look) begin
                    if (!(lk_ack && lk_valid == e.ok && lk_data == e.data)) begin
                        mon_errs++;
                        $display("FAIL R%0d lookup ack=%0b valid=%0b data=%h expected valid=%0b data=%h",
                                 e.rq, lk_ack, lk_valid, lk_data, e.ok, e.data);
                    end
                end else begin
                    if (!(cmd_done && cmd_ok == e.ok && err_flag == e.err)) begin
                        mon_errs++;
                        $display("FAIL R%0d command done=%0b ok=%0b err=%0b expected ok=%0b err=%0b",
                                 e.rq, cmd_done, cmd_ok, err_flag, e.ok, e.err);
                    end
                end
            end
        end
    end

    int          checks = 0, errors = 0;
    bit          c_valid = 1'b0;
    logic [15:0] cimg [WORDS];

    task automatic chk(input bit good, input string what, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_op();
        do begin
            @(posedge clk); #1;
        end while (busy || sb.size() != 0);
    endtask

    task automatic push_img();
        @(posedge clk); #1 img_load = 1'b1;
        @(posedge clk); #1 img_load = 1'b0;
    endtask

    task automatic fill(input logic [15:0] base, input bit sig_good, input bit sum_good);
        logic [15:0] s = '0;
        for (int i = 0; i < WORDS - 1; i++) begin
            bimg[i] = base + 16'(i * 16'h0123);
            if (i == 0) bimg[0] = {(sig_good ? 2'b01 : 2'b10), bimg[0][13:0]};
            s += bimg[i];
        end
        bimg[WORDS-1] = TARGET - s + (sum_good ? 16'd0 : 16'd1);
        push_img();
    endtask

    function automatic bit img_good();
        logic [15:0] s = '0;
        for (int i = 0; i < WORDS; i++) s += bimg[i];
        return (s == TARGET) && ((bimg[0] & 16'hC000) == 16'h4000);
    endfunction

    task automatic do_load(input int rq);
        exp_t e;
        int   r0 = rd_cnt;
        bit   ok = img_good();
        e = '{is_look: 1'b0, ok: ok, data: 16'h0, err: 1'b0, rq: rq};
        sb.push_back(e);
        @(posedge clk); #1 cmd_load = 1'b1;
        @(posedge clk); #1 cmd_load = 1'b0;
        finish_op();
        chk(rd_cnt - r0 == 64, "R2 load read count", rd_cnt - r0, 64);
        c_valid = ok;
        if (ok) cimg = bimg;
    endtask

    task automatic do_lookup(input logic [6:0] idx, input int rq);
        exp_t e;
        int   r0 = rd_cnt;
        int   exp_rd = 0;
        bit   ok;
        if (idx >= 7'd64) begin
            e = '{is_look: 1'b1, ok: 1'b0, data: 16'h0, err: 1'b0, rq: rq};
        end else if (c_valid) begin
            e = '{is_look: 1'b1, ok: 1'b1, data: cimg[idx[5:0]], err: 1'b0, rq: rq};
        end else begin
            ok     = img_good();
            exp_rd = 64;
            e = '{is_look: 1'b1, ok: ok, data: (ok ? bimg[idx[5:0]] : 16'h0), err: 1'b0, rq: rq};
            c_valid = ok;
            if (ok) cimg = bimg;
        end
        sb.push_back(e);
        @(posedge clk); #1 lk_req = 1'b1; lk_index = idx;
        @(posedge clk); #1 lk_req = 1'b0;
        finish_op();
        chk(rd_cnt - r0 == exp_rd, $sformatf("R%0d lookup read count idx=%0d", rq, idx),
            rd_cnt - r0, exp_rd);
    endtask

    task automatic do_update();
        exp_t        e;
        int          r0 = rd_cnt, w0 = wr_cnt;
        logic [15:0] s = '0;
        logic [15:0] fx;
        for (int i = 0; i < WORDS - 1; i++) s += bimg[i];
        fx = TARGET - s;
        e = '{is_look: 1'b0, ok: 1'b1, data: 16'h0, err: 1'b0, rq: 9};
        sb.push_back(e);
        @(posedge clk); #1 cmd_update = 1'b1;
        @(posedge clk); #1 cmd_update = 1'b0;
        finish_op();
        chk(rd_cnt - r0 == 63, "R9 update read count", rd_cnt - r0, 63);
        chk(wr_cnt - w0 == 1, "R9 update write count", wr_cnt - w0, 1);
        chk(last_waddr == 6'd63, "R9 fix-up address", last_waddr, 63);
        chk(last_wdata == fx, "R9 fix-up value", last_wdata, fx);
        bimg[WORDS-1] = fx;
        c_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
        $finish;
    end

    initial begin
        exp_t e;
        int   r0, w0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(!busy && !mem_req, "R1 busy/mem_req after reset", {busy, mem_req}, 0);
        chk(!cmd_done && !lk_ack && !err_flag, "R1 strobes/err after reset",
            {cmd_done, lk_ack, err_flag}, 0);

        // R3 good image loads; R6 hits; R8 out of range
        fill(16'h1111, 1'b1, 1'b1);
        do_load(3);
        do_lookup(7'd0, 6);
        do_lookup(7'd5, 6);
        do_lookup(7'd63, 6);
        do_lookup(7'd64, 8);
        do_lookup(7'd127, 8);

        // R4 bad sum with good signature: word 0 cleared, lookup reloads
        fill(16'h2222, 1'b1, 1'b0);
        do_load(4);
        do_lookup(7'd3, 4);

        // R5 good sum, bad signature
        fill(16'h3333, 1'b0, 1'b1);
        do_load(5);

        // R7 lazy reload then R6 hit
        fill(16'h4444, 1'b1, 1'b1);
        do_lookup(7'd7, 7);
        do_lookup(7'd7, 6);

        // R9 update after corrupting word 10; R10 the write forces a reload
        bimg[10] = bimg[10] ^ 16'h00FF;
        push_img();
        do_update();
        do_lookup(7'd10, 10);
        do_lookup(7'd10, 6);

        // R11 timeout inside an update read burst
        to_at = rd_cnt + 10;
        e = '{is_look: 1'b0, ok: 1'b0, data: 16'h0, err: 1'b1, rq: 11};
        sb.push_back(e);
        @(posedge clk); #1 cmd_update = 1'b1;
        @(posedge clk); #1 cmd_update = 1'b0;
        finish_op();
        to_at   = -1;
        c_valid = 1'b0;
        chk(err_flag == 1'b1, "R11 err_flag after timeout", err_flag, 1);
        do_lookup(7'd2, 11);
        // R11 timeout inside a lookup reload
        c_valid = 1'b0;
        bimg[20] = bimg[20] + 16'd1;
        bimg[21] = bimg[21] - 16'd1;
        push_img();
        do_load(3);
        r0 = rd_cnt;
        to_at = rd_cnt + 40;
        bimg[30] = bimg[30] + 16'd5;
        bimg[31] = bimg[31] - 16'd5;
        push_img();
        c_valid = 1'b1;
        // cache still valid from the load: hit first, then invalidate by update
        do_lookup(7'd30, 6);
        to_at = -1;
        do_update();
        to_at = rd_cnt + 40;
        e = '{is_look: 1'b1, ok: 1'b0, data: 16'h0, err: 1'b0, rq: 11};
        sb.push_back(e);
        @(posedge clk); #1 lk_req = 1'b1; lk_index = 7'd30;
        @(posedge clk); #1 lk_req = 1'b0;
        finish_op();
        to_at = -1;
        chk(err_flag == 1'b1, "R11 err_flag after lookup timeout", err_flag, 1);
        do_load(11);
        chk(err_flag == 1'b0, "R11 err_flag cleared by next command", err_flag, 0);

        // R12 update and lookup together: lookup dropped; load while busy ignored
        r0 = rd_cnt;
        e = '{is_look: 1'b0, ok: 1'b1, data: 16'h0, err: 1'b0, rq: 12};
        sb.push_back(e);
        @(posedge clk); #1 cmd_update = 1'b1; lk_req = 1'b1; lk_index = 7'd4;
        @(posedge clk); #1 cmd_update = 1'b0; lk_req = 1'b0;
        repeat (20) @(posedge clk);
        #1 cmd_load = 1'b1;
        @(posedge clk); #1 cmd_load = 1'b0;
        finish_op();
        repeat (5) @(posedge clk);
        #1;
        chk(rd_cnt - r0 == 63, "R12 only the update ran", rd_cnt - r0, 63);
        begin
            logic [15:0] s = '0;
            for (int i = 0; i < WORDS - 1; i++) s += bimg[i];
            bimg[WORDS-1] = TARGET - s;
        end
        c_valid = 1'b0;

        // R12 load and update together: load wins, no write
        r0 = rd_cnt;
        w0 = wr_cnt;
        e = '{is_look: 1'b0, ok: img_good(), data: 16'h0, err: 1'b0, rq: 12};
        sb.push_back(e);
        @(posedge clk); #1 cmd_load = 1'b1; cmd_update = 1'b1;
        @(posedge clk); #1 cmd_load = 1'b0; cmd_update = 1'b0;
        finish_op();
        chk(rd_cnt - r0 == 64 && wr_cnt == w0, "R12 load wins over update",
            rd_cnt - r0, 64);

        // R2 ascending order over every read burst
        chk(order_bad == 0, "R2 read address order", order_bad, 0);

        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    end
endmodule